// File: doc/BRIEF.md
# Display Pixel Formatter with 4:2:2 Chroma Decimation

The formatter sits between a video encoder and a display-serial host. Each pixel clock it takes one pixel of three components along with data-enable, horizontal and vertical sync. It returns a parallel pixel word and the three syncs after a fixed two-cycle delay. A single control word sets four things: how wide the incoming components are, which incoming component feeds each output slot, whether each sync input must be inverted, and how chroma is decimated.

There are two output layouts. The first is 24-bit RGB, one byte per component. The second is 16-bit YCbCr 4:2:2, where every pixel carries its own luma and the chroma bytes alternate, Cb then Cr. The 4:2:2 chroma for a pixel pair can come from the even pixel, from the odd pixel, or from the rounded average of the two. The pair is formed by holding each pixel for one cycle, which is why data and syncs always come out two clocks after they go in.

Top module: `dpi_pix_fmt`

## Requirements
- R1: While rst_ni is low and on the first output after release, pix_o, de_o, hs_o and vs_o are all zero.
- R2: Each corrected sync (DE, HSYNC, VSYNC) appears on de_o, hs_o and vs_o exactly two clock edges after it is presented. The corrected value is the input XOR its invert bit: ctrl_i[10] for DE, ctrl_i[11] for HSYNC and ctrl_i[12] for VSYNC.
- R3: ctrl_i[1:0] selects the input width. Input lane k is pix_i[10k+9:10k].
  - Code 0: take lane[9:2].
  - Code 1: take lane[7:0].
  - Code 2: a 6-bit value in lane[5:0].
  - Code 3: 5/6/5 bits in the low bits of lanes 0, 1 and 2.
  - Narrow values are shifted up to 8 bits, and their top bits are repeated into the vacated low bits.
- R4: Output component j is taken from the input lane named by its selector: ctrl_i[3:2] for j=0, ctrl_i[5:4] for j=1, ctrl_i[7:6] for j=2. Selector code 3 yields zero.
- R5: With format code ctrl_i[16:13]=5 (RGB), pix_o = {comp0, comp1, comp2}.
- R6: With format code 8 (YCbCr 4:2:2), pix_o[23:16]=0 and pix_o[15:8]=comp0 (Y). pix_o[7:0] carries Cb (comp1) on even pixels of a line and Cr (comp2) on odd pixels.
- R7: Chroma mode ctrl_i[9:8]=0 (and the unused code 3) takes both Cb and Cr of a pair from the even pixel.
- R8: Chroma mode 1 takes both Cb and Cr of a pair from the odd pixel.
- R9: Chroma mode 2 uses (even+odd+1)>>1 for Cb and for Cr.
- R10: Pixel numbering restarts at 0 on every rising edge of the corrected DE. The final even pixel of a line with an odd pixel count uses its own Cb in every mode.
- R11: Any format code other than 5 or 8 drives pix_o to zero, while the corrected syncs still pass through.
- R12: pix_o is zero whenever de_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 30 | Three 10-bit input lanes |
| de_i | input | 1 | Data enable, raw polarity |
| hs_i | input | 1 | Horizontal sync, raw polarity |
| vs_i | input | 1 | Vertical sync, raw polarity |
| ctrl_i | input | 17 | Control word (fields in R2–R11) |
| pix_o | output | 24 | Formatted pixel word |
| de_o | output | 1 | Corrected data enable, delayed two cycles |
| hs_o | output | 1 | Corrected horizontal sync, delayed two cycles |
| vs_o | output | 1 | Corrected vertical sync, delayed two cycles |

## Verification
Several properties are checked on every cycle:
- the two-cycle delay on the corrected syncs;
- blanking of the pixel word outside DE;
- zero output for unsupported formats;
- the cleared upper byte in 4:2:2 mode;
- the restart and alternation of pixel parity along a line.

The actual component values need the bench's scenarios, which compare against expected values computed in the bench. These cover width expansion and slot routing, and the chroma chosen in each decimation mode. They also cover the unpaired last pixel of an odd-length line.

// File: rtl/dpi_fmt_pkg.sv
package dpi_fmt_pkg;

  typedef struct packed {
    logic [3:0] out_fmt;   // [16:13]
    logic       vs_inv;    // [12]
    logic       hs_inv;    // [11]
    logic       de_inv;    // [10]
    logic [1:0] chroma;    // [9:8]
    logic [1:0] sel2;      // [7:6]
    logic [1:0] sel1;      // [5:4]
    logic [1:0] sel0;      // [3:2]
    logic [1:0] in_width;  // [1:0]
  } fmt_ctrl_t;

  localparam int CTRL_W = $bits(fmt_ctrl_t);

  localparam logic [3:0] FMT_RGB888 = 4'd5;
  localparam logic [3:0] FMT_YC422  = 4'd8;

  localparam logic [1:0] WID_30 = 2'd0;
  localparam logic [1:0] WID_24 = 2'd1;
  localparam logic [1:0] WID_18 = 2'd2;
  localparam logic [1:0] WID_16 = 2'd3;

  localparam logic [1:0] CHR_EVEN = 2'd0;
  localparam logic [1:0] CHR_ODD  = 2'd1;
  localparam logic [1:0] CHR_AVG  = 2'd2;

  // integration default: selectors 0/1/2, no inversion, RGB888, 24-bit input
  localparam fmt_ctrl_t CTRL_DEFAULT = '{out_fmt: FMT_RGB888, vs_inv: 1'b0,
    hs_inv: 1'b0, de_inv: 1'b0, chroma: CHR_EVEN, sel2: 2'd2, sel1: 2'd1,
    sel0: 2'd0, in_width: WID_24};

endpackage

// File: rtl/dpi_sync_norm.sv
module dpi_sync_norm #(
  parameter int N = 3
) (
  input  logic [N-1:0] sig_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] sig_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign sig_o[g] = sig_i[g] ^ inv_i[g];
  end
endmodule

// File: rtl/dpi_comp_unpack.sv
module dpi_comp_unpack
  import dpi_fmt_pkg::*;
#(
  parameter int LANE_W = 10,
  parameter int CW     = 8
) (
  input  logic [3*LANE_W-1:0] pix_i,
  input  logic [1:0]          width_i,
  input  logic [2:0][1:0]     sel_i,
  output logic [2:0][CW-1:0]  comp_o
);
  localparam int BITS_WIDE   = CW - 2;
  localparam int BITS_NARROW = CW - 3;

  // left-align a bits-wide value, repeating its MSBs into the low bits
  function automatic logic [CW-1:0] widen(input logic [CW-1:0] v, input int bits);
    logic [CW-1:0] r;
    for (int i = 0; i < CW; i++) r[i] = v[bits - 1 - ((CW - 1 - i) % bits)];
    return r;
  endfunction

  logic [2:0][CW-1:0] lane_x;

  for (genvar g = 0; g < 3; g++) begin : g_lane
    localparam int B16 = (g == 1) ? BITS_WIDE : BITS_NARROW;
    logic [LANE_W-1:0] lane;
    assign lane = pix_i[g*LANE_W +: LANE_W];
    always_comb begin
      unique case (width_i)
        WID_30:  lane_x[g] = lane[LANE_W-1 -: CW];
        WID_24:  lane_x[g] = lane[CW-1:0];
        WID_18:  lane_x[g] = widen(lane[CW-1:0], BITS_WIDE);
        default: lane_x[g] = widen(lane[CW-1:0], B16);
      endcase
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_slot
    always_comb begin
      unique case (sel_i[k])
        2'd0:    comp_o[k] = lane_x[0];
        2'd1:    comp_o[k] = lane_x[1];
        2'd2:    comp_o[k] = lane_x[2];
        default: comp_o[k] = '0;
      endcase
    end
  end
endmodule

// File: rtl/dpi_chroma_pair.sv
module dpi_chroma_pair
  import dpi_fmt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          de_in_i,   // corrected DE entering stage 1
  input  logic [CW-1:0] cb_in_i,   // Cb of the pixel entering stage 1
  input  logic          de_s1_i,
  input  logic [CW-1:0] cb_s1_i,
  input  logic [CW-1:0] cr_s1_i,
  output logic          odd_o,
  output logic [CW-1:0] chroma_o
);
  logic          odd_q;
  logic [CW-1:0] even_cr_q;
  logic          line_start;
  logic          has_mate;

  assign line_start = de_in_i & ~de_s1_i;
  assign has_mate   = de_in_i;     // stage 1 holds DE high, so no new line yet

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q     <= 1'b0;
      even_cr_q <= '0;
    end else begin
      odd_q <= de_in_i & ~line_start & ~odd_q;
      if (de_s1_i && !odd_q) even_cr_q <= cr_s1_i;
    end
  end

  function automatic logic [CW-1:0] avg(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{CW{1'b0}}, 1'b1};
    return s[CW:1];
  endfunction

  always_comb begin
    if (!odd_q) begin
      unique case (mode_i)
        CHR_ODD: chroma_o = has_mate ? cb_in_i : cb_s1_i;
        CHR_AVG: chroma_o = has_mate ? avg(cb_s1_i, cb_in_i) : cb_s1_i;
        default: chroma_o = cb_s1_i;
      endcase
    end else begin
      unique case (mode_i)
        CHR_ODD: chroma_o = cr_s1_i;
        CHR_AVG: chroma_o = avg(even_cr_q, cr_s1_i);
        default: chroma_o = even_cr_q;
      endcase
    end
  end

  assign odd_o = odd_q;

  assert_parity_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start |=> !odd_q);
  assert_parity_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_in_i && de_s1_i) |=> (odd_q != $past(odd_q)));
endmodule

// File: rtl/dpi_pix_fmt.sv
module dpi_pix_fmt
  import dpi_fmt_pkg::*;
#(
  parameter int LANE_W = 10,
  parameter int CW     = 8,
  localparam int IN_W  = 3 * LANE_W,
  localparam int OUT_W = 3 * CW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   pix_i,
  input  logic              de_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [OUT_W-1:0]  pix_o,
  output logic              de_o,
  output logic              hs_o,
  output logic              vs_o
);
  fmt_ctrl_t ctrl;
  assign ctrl = fmt_ctrl_t'(ctrl_i);

  logic [2:0] sync_n;  // {vs, hs, de} corrected
  dpi_sync_norm #(.N(3)) u_sync (
    .sig_i({vs_i, hs_i, de_i}),
    .inv_i({ctrl.vs_inv, ctrl.hs_inv, ctrl.de_inv}),
    .sig_o(sync_n)
  );

  logic [2:0][CW-1:0] comp_in;
  dpi_comp_unpack #(.LANE_W(LANE_W), .CW(CW)) u_unpack (
    .pix_i  (pix_i),
    .width_i(ctrl.in_width),
    .sel_i  ({ctrl.sel2, ctrl.sel1, ctrl.sel0}),
    .comp_o (comp_in)
  );

  // stage 1
  logic               de_s1, hs_s1, vs_s1;
  logic [2:0][CW-1:0] comp_s1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_s1   <= 1'b0;
      hs_s1   <= 1'b0;
      vs_s1   <= 1'b0;
      comp_s1 <= '0;
    end else begin
      de_s1   <= sync_n[0];
      hs_s1   <= sync_n[1];
      vs_s1   <= sync_n[2];
      comp_s1 <= comp_in;
    end
  end

  logic          odd_s1;
  logic [CW-1:0] chroma;
  dpi_chroma_pair #(.CW(CW)) u_chroma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (ctrl.chroma),
    .de_in_i (sync_n[0]),
    .cb_in_i (comp_in[1]),
    .de_s1_i (de_s1),
    .cb_s1_i (comp_s1[1]),
    .cr_s1_i (comp_s1[2]),
    .odd_o   (odd_s1),
    .chroma_o(chroma)
  );

  logic [OUT_W-1:0] pix_nxt;
  always_comb begin
    pix_nxt = '0;
    if (de_s1) begin
      unique case (ctrl.out_fmt)
        FMT_RGB888: pix_nxt = {comp_s1[0], comp_s1[1], comp_s1[2]};
        FMT_YC422:  pix_nxt = {{(OUT_W-2*CW){1'b0}}, comp_s1[0], chroma};
        default:    pix_nxt = '0;
      endcase
    end
  end

  // stage 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0;
      de_o  <= 1'b0;
      hs_o  <= 1'b0;
      vs_o  <= 1'b0;
    end else begin
      pix_o <= pix_nxt;
      de_o  <= de_s1;
      hs_o  <= hs_s1;
      vs_o  <= vs_s1;
    end
  end

  // cycles since reset, saturating at 2
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_sync_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (de_o == $past(sync_n[0], 2) && hs_o == $past(sync_n[1], 2)
                         && vs_o == $past(sync_n[2], 2)));
  assert_blank_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (pix_o == '0));
  assert_unsupported_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.out_fmt != FMT_RGB888 && ctrl.out_fmt != FMT_YC422) |=> (pix_o == '0));
  assert_yc_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.out_fmt == FMT_YC422) |=> (pix_o[OUT_W-1:2*CW] == '0));
  assert_odd_is_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_s1 |-> de_s1);
endmodule

// File: tb/tb_dpi_pix_fmt.sv
`timescale 1ns/1ps
module tb_dpi_pix_fmt;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [29:0] pix_i = '0;
  logic        de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic [16:0] ctrl_i = '0;
  logic [23:0] pix_o;
  logic        de_o, hs_o, vs_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpi_pix_fmt dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix_i), .de_i(de_i), .hs_i(hs_i),
    .vs_i(vs_i), .ctrl_i(ctrl_i), .pix_o(pix_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o)
  );

  function automatic logic [16:0] mk_ctrl(input logic [3:0] fmt, input logic [1:0] chr,
      input logic [2:0] inv, input logic [1:0] s0, input logic [1:0] s1,
      input logic [1:0] s2, input logic [1:0] w);
    return {fmt, inv, chr, s2, s1, s0, w};
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  w;
    logic [1:0]  s0, s1, s2;
    logic [29:0] pix;
    logic [23:0] exp;
  } vec_t;

  // R3 width expansion, R4 slot routing, R5 RGB layout
  localparam vec_t VEC [6] = '{
    '{2'd1, 2'd0, 2'd1, 2'd2, {10'h056, 10'h034, 10'h012}, 24'h123456},
    '{2'd0, 2'd0, 2'd1, 2'd2, {10'h003, 10'h200, 10'h3FF}, 24'hFF8000},
    '{2'd2, 2'd0, 2'd1, 2'd2, {10'h001, 10'h020, 10'h03F}, 24'hFF8204},
    '{2'd3, 2'd0, 2'd1, 2'd2, {10'h010, 10'h021, 10'h01F}, 24'hFF8684},
    '{2'd1, 2'd2, 2'd0, 2'd1, {10'h033, 10'h022, 10'h011}, 24'h331122},
    '{2'd1, 2'd3, 2'd1, 2'd1, {10'h033, 10'h022, 10'h011}, 24'h002222}
  };

  function automatic logic [7:0] avg8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction

  // one 4:2:2 line of len pixels, then two blank cycles
  task automatic run_line(input logic [1:0] mode, input int len, input int seed,
                          input string req);
    logic [7:0]  y [16];
    logic [7:0]  cb [16];
    logic [7:0]  cr [16];
    logic [23:0] exp [16];
    for (int i = 0; i < len; i++) begin
      y[i]  = 8'(seed * 17 + i * 29);
      cb[i] = 8'(seed * 5 + i * 71 + 3);
      cr[i] = 8'(seed * 11 + i * 45 + 200);
    end
    for (int i = 0; i < len; i++) begin
      logic [7:0] c;
      if (i % 2 == 0) begin
        if (i + 1 >= len)        c = cb[i];
        else if (mode == 2'd1)   c = cb[i+1];
        else if (mode == 2'd2)   c = avg8(cb[i], cb[i+1]);
        else                     c = cb[i];
      end else begin
        if (mode == 2'd1)        c = cr[i];
        else if (mode == 2'd2)   c = avg8(cr[i-1], cr[i]);
        else                     c = cr[i-1];
      end
      exp[i] = {8'h00, y[i], c};
    end
    ctrl_i = mk_ctrl(4'd8, mode, 3'b000, 2'd0, 2'd1, 2'd2, 2'd1);
    for (int t = 0; t < len + 2; t++) begin
      @(negedge clk);
      if (t >= 2) check(pix_o == exp[t-2] && de_o, req, pix_o, exp[t-2]);
      de_i  = (t < len);
      pix_i = (t < len) ? {2'b0, cr[t], 2'b0, cb[t], 2'b0, y[t]} : '0;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 24'h0, 24'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    ctrl_i = mk_ctrl(4'd5, 2'd0, 3'b000, 2'd0, 2'd1, 2'd2, 2'd1);
    de_i = 1'b1; hs_i = 1'b1; vs_i = 1'b1; pix_i = 30'h3FFFFFFF;
    repeat (3) @(negedge clk);
    check(pix_o == '0 && !de_o && !hs_o && !vs_o, "R1 reset", pix_o, 24'h0);
    de_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0; pix_i = '0;
    rst_ni = 1'b1;
    @(negedge clk);
    check(pix_o == '0 && !de_o, "R1 first out", pix_o, 24'h0);
    repeat (2) @(negedge clk);

    // vector table
    foreach (VEC[i]) begin
      ctrl_i = mk_ctrl(4'd5, 2'd0, 3'b000, VEC[i].s0, VEC[i].s1, VEC[i].s2, VEC[i].w);
      pix_i  = VEC[i].pix;
      de_i   = 1'b1;
      repeat (2) @(negedge clk);
      check(pix_o == VEC[i].exp, "R3/R4/R5 vector", pix_o, VEC[i].exp);
    end
    de_i = 1'b0;
    repeat (3) @(negedge clk);

    // R2: inversion and two-cycle delay
    ctrl_i = mk_ctrl(4'd5, 2'd0, 3'b101, 2'd0, 2'd1, 2'd2, 2'd1);
    de_i = 1'b1; hs_i = 1'b1; vs_i = 1'b1;   // corrected: de=0, hs=1, vs=0
    repeat (3) @(negedge clk);
    check({vs_o, hs_o, de_o} == 3'b010, "R2 inverted syncs", {21'h0, vs_o, hs_o, de_o}, 24'h2);
    de_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0;   // corrected: de=1, hs=0, vs=1
    @(negedge clk);
    check({vs_o, hs_o, de_o} == 3'b010, "R2 one cycle no change", {21'h0, vs_o, hs_o, de_o}, 24'h2);
    @(negedge clk);
    check({vs_o, hs_o, de_o} == 3'b101, "R2 after two cycles", {21'h0, vs_o, hs_o, de_o}, 24'h5);

    // R11: unsupported format, syncs still pass
    ctrl_i = mk_ctrl(4'd3, 2'd0, 3'b000, 2'd0, 2'd1, 2'd2, 2'd1);
    de_i = 1'b1; hs_i = 1'b1; vs_i = 1'b0; pix_i = {10'h0AA, 10'h0BB, 10'h0CC};
    repeat (2) @(negedge clk);
    check(pix_o == '0 && de_o && hs_o && !vs_o, "R11 unsupported", pix_o, 24'h0);

    // R12: DE low blanks pixel
    ctrl_i = mk_ctrl(4'd5, 2'd0, 3'b000, 2'd0, 2'd1, 2'd2, 2'd1);
    de_i = 1'b0; hs_i = 1'b0;
    repeat (2) @(negedge clk);
    check(pix_o == '0 && !de_o, "R12 blank", pix_o, 24'h0);
    pix_i = '0;
    @(negedge clk);

    // 4:2:2 lines
    run_line(2'd0, 4, 1, "R6/R7 even chroma");
    run_line(2'd1, 4, 2, "R8 odd chroma");
    run_line(2'd2, 6, 3, "R9 average chroma");
    run_line(2'd1, 5, 4, "R10 odd-length line, odd mode");
    run_line(2'd2, 3, 5, "R10 restart after odd line");
    run_line(2'd3, 4, 6, "R7 mode 3 as even");
    run_line(2'd2, 1, 7, "R10 single pixel line");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule